// File: doc/BRIEF.md
# Byte-exact 16-bit bus access sequencer

This block sits between a processor-side port that issues small data fragments (one, two or three bytes at any byte address) and a 16-bit peripheral bus whose reads may have side effects. It turns each fragment into the shortest possible series of bus cycles. Reads always fetch whole 16-bit words. Writes combine byte and word cycles so that no byte outside the fragment is ever written. The block never uses a read-modify-write.

A fragment is accepted on a one-cycle `req_i` pulse while the block is idle. Each bus cycle is presented with `bus_req_o` and held until the bus returns `bus_ack_i`. After the final acknowledge, `done_o` pulses for one cycle. For reads, `rdata_o` holds the assembled 32-bit image from the `done_o` cycle until the next request.

Top module: `iob_seq`

## Requirements
- R1: After reset `busy_o`, `bus_req_o` and `done_o` are low, and `bus_req_o` is never high while `busy_o` is low.
- R2: A read with length + address bit 0 not above 2 issues exactly one word read at the request address. The word appears in `rdata_o[31:16]` when address bit 1 is 1, and in `rdata_o[15:0]` otherwise. The unused half is zero.
- R3: Any other read issues two word reads, first at the request address and then at address + 2. The first word forms `rdata_o[15:0]` and the second forms `rdata_o[31:16]`.
- R4: Read cycles always have `bus_byte_o` low (word cycle) and `bus_wr_o` low.
- R5: A 1-byte write is one byte cycle at the request address. The byte is on `bus_wdata_o[15:8]` when address bit 0 is 1, otherwise on `bus_wdata_o[7:0]`, and the other lane is zero.
- R6: A 2-byte write to an even address is one word cycle carrying `wdata_i[15:0]`. To an odd address it is two byte cycles: `wdata_i[7:0]` at the address, then `wdata_i[15:8]` at address + 1.
- R7: A 3-byte write to an even address is a word cycle carrying `wdata_i[15:0]`, then a byte cycle at address + 2 carrying `wdata_i[23:16]`.
- R8: A 3-byte write to an odd address is a byte cycle carrying `wdata_i[7:0]`, then a word cycle at address + 1 carrying `wdata_i[23:8]`.
- R9: While `bus_req_o` is high without `bus_ack_i`, the bus request and its address, direction, size and write data stay unchanged in the next cycle.
- R10: `done_o` is a one-cycle pulse in the cycle after the final acknowledge, and no request produces more than two acknowledged bus cycles.
- R11: `req_i` is ignored while `busy_o` is high, so the current sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start pulse; taken only while idle |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address of the fragment |
| req_len_i | input | 2 | Length in bytes (1, 2 or 3) |
| req_wdata_i | input | 24 | Write data, right-aligned |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Assembled read image |
| bus_req_o | output | 1 | Bus cycle request |
| bus_ack_i | input | 1 | Bus cycle acknowledge |
| bus_addr_o | output | ADDR_W | Bus byte address |
| bus_wr_o | output | 1 | Bus write strobe |
| bus_byte_o | output | 1 | 1 = byte cycle, 0 = word cycle |
| bus_wdata_o | output | 16 | Bus write data |
| bus_rdata_i | input | 16 | Bus read data |

## Verification
The assertions check several properties on every cycle. Read cycles are always word-sized. A pending cycle is held stable until its acknowledge. `done_o` lasts a single cycle and follows an acknowledge. No request goes past two acknowledged cycles. The exact cycle table depends on address parity and length, and only the bench scenarios show it. That table covers the count, order, addresses, lane placement and write data of each cycle, and also where the read words land in the returned image. The bench scenarios also show that a start pulse during a sequence is ignored.

// File: rtl/iob_pkg.sv
package iob_pkg;
  typedef struct packed {
    logic [1:0]  inc;     // address offset from request
    logic        byte_w;  // byte cycle
    logic [15:0] data;    // lane-placed write data
  } step_t;
endpackage

// File: rtl/iob_plan.sv
module iob_plan
  import iob_pkg::*;
(
  input  logic        wr_i,
  input  logic        a0_i,
  input  logic [1:0]  len_i,
  input  logic [23:0] wdata_i,
  output logic        two_o,
  output step_t       s0_o,
  output step_t       s1_o
);
  logic [7:0] b0, b1, b2;
  assign b0 = wdata_i[7:0];
  assign b1 = wdata_i[15:8];
  assign b2 = wdata_i[23:16];

  always_comb begin
    two_o = 1'b0;
    s0_o  = '0;
    s1_o  = '0;
    if (!wr_i) begin
      two_o     = ({1'b0, len_i} + {2'b00, a0_i}) > 3'd2;
      s1_o.inc  = 2'd2;
    end else begin
      unique case (len_i)
        2'd2: begin
          if (a0_i) begin
            two_o = 1'b1;
            s0_o  = '{inc: 2'd0, byte_w: 1'b1, data: {b0, 8'h00}};
            s1_o  = '{inc: 2'd1, byte_w: 1'b1, data: {8'h00, b1}};
          end else begin
            s0_o  = '{inc: 2'd0, byte_w: 1'b0, data: {b1, b0}};
          end
        end
        2'd3: begin
          two_o = 1'b1;
          if (a0_i) begin
            s0_o = '{inc: 2'd0, byte_w: 1'b1, data: {b0, 8'h00}};
            s1_o = '{inc: 2'd1, byte_w: 1'b0, data: {b2, b1}};
          end else begin
            s0_o = '{inc: 2'd0, byte_w: 1'b0, data: {b1, b0}};
            s1_o = '{inc: 2'd2, byte_w: 1'b1, data: {8'h00, b2}};
          end
        end
        default: begin
          s0_o = '{inc: 2'd0, byte_w: 1'b1,
                   data: a0_i ? {b0, 8'h00} : {8'h00, b0}};
        end
      endcase
    end
  end
endmodule

// File: rtl/iob_rd_pack.sv
module iob_rd_pack (
  input  logic        two_i,
  input  logic        a1_i,
  input  logic [15:0] w0_i,
  input  logic [15:0] w1_i,
  output logic [31:0] img_o
);
  always_comb begin
    if (two_i)     img_o = {w1_i, w0_i};
    else if (a1_i) img_o = {w0_i, 16'h0000};
    else           img_o = {16'h0000, w0_i};
  end
endmodule

// File: rtl/iob_seq.sv
module iob_seq
  import iob_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              req_wr_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_len_i,
  input  logic [23:0]       req_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [31:0]       rdata_o,
  output logic              bus_req_o,
  input  logic              bus_ack_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_wr_o,
  output logic              bus_byte_o,
  output logic [15:0]       bus_wdata_o,
  input  logic [15:0]       bus_rdata_i
);
  localparam int NSTEP = 2;

  step_t             plan_s0, plan_s1;
  logic              plan_two;
  step_t             step_q [NSTEP];
  logic              two_q, wr_q, busy_q, done_q, idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       word_q [NSTEP];
  step_t             cur;
  logic              accept, fire, last;

  iob_plan u_plan (
    .wr_i    (req_wr_i),
    .a0_i    (req_addr_i[0]),
    .len_i   (req_len_i),
    .wdata_i (req_wdata_i),
    .two_o   (plan_two),
    .s0_o    (plan_s0),
    .s1_o    (plan_s1)
  );

  assign accept = req_i && !busy_q;
  assign fire   = busy_q && bus_ack_i;
  assign last   = (idx_q == two_q);
  assign cur    = step_q[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= 1'b0;
      two_q  <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      done_q <= fire && last;
      if (accept) begin
        busy_q <= 1'b1;
        idx_q  <= 1'b0;
        two_q  <= plan_two;
        wr_q   <= req_wr_i;
        addr_q <= req_addr_i;
      end else if (fire) begin
        if (last) busy_q <= 1'b0;
        else      idx_q  <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NSTEP; g++) begin : g_step
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        step_q[g] <= '0;
        word_q[g] <= '0;
      end else begin
        if (accept) begin
          step_q[g] <= (g == 0) ? plan_s0 : plan_s1;
          word_q[g] <= '0;
        end else if (fire && !wr_q && (idx_q == 1'(g))) begin
          word_q[g] <= bus_rdata_i;
        end
      end
    end
  end

  iob_rd_pack u_pack (
    .two_i (two_q),
    .a1_i  (addr_q[1]),
    .w0_i  (word_q[0]),
    .w1_i  (word_q[1]),
    .img_o (rdata_o)
  );

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign bus_req_o   = busy_q;
  assign bus_addr_o  = addr_q + ADDR_W'(cur.inc);
  assign bus_wr_o    = wr_q;
  assign bus_byte_o  = wr_q && cur.byte_w;
  assign bus_wdata_o = wr_q ? cur.data : 16'h0000;
endmodule

// File: rtl/iob_seq_chk.sv
module iob_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              bus_req_o,
  input logic              bus_ack_i,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_wr_o,
  input logic              bus_byte_o,
  input logic [15:0]       bus_wdata_o
);
  logic [2:0] ack_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ack_cnt <= '0;
    else if (done_o)                 ack_cnt <= '0;
    else if (bus_req_o && bus_ack_i) ack_cnt <= ack_cnt + 3'd1;
  end

  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !bus_req_o); // R1
  AST_READ_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_wr_o) |-> !bus_byte_o); // R4
  AST_HOLD_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_wr_o)
                                   && $stable(bus_byte_o) && $stable(bus_wdata_o))); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_DONE_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(bus_req_o && bus_ack_i)); // R10
  AST_MAX_CYCLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_cnt <= 3'd2); // R10
endmodule

bind iob_seq iob_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .bus_req_o   (bus_req_o),
  .bus_ack_i   (bus_ack_i),
  .bus_addr_o  (bus_addr_o),
  .bus_wr_o    (bus_wr_o),
  .bus_byte_o  (bus_byte_o),
  .bus_wdata_o (bus_wdata_o)
);

// File: tb/iob_seq_tb.sv
module iob_seq_tb_top;
  localparam int AW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, req_wr_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [1:0]    req_len_i = 2'd1;
  logic [23:0]   req_wdata_i = '0;
  logic          busy_o, done_o, bus_req_o, bus_wr_o, bus_byte_o;
  logic          bus_ack_i = 1'b0;
  logic [31:0]   rdata_o;
  logic [AW-1:0] bus_addr_o;
  logic [15:0]   bus_wdata_o;
  logic [15:0]   bus_rdata_i = '0;

  int checks = 0, errors = 0;
  int ncyc;
  logic [AW-1:0] log_a [4];
  logic          log_w [4];
  logic          log_b [4];
  logic [15:0]   log_d [4];

  always #4ns clk_i = ~clk_i;

  iob_seq #(.ADDR_W(AW)) dut_i (.*);

  function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
    logic [AW-1:0] e;
    e = a & ~AW'(1);
    return {e[7:0] ^ 8'h5A, e[7:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // bus responder
  initial begin
    forever begin
      @(negedge clk_i);
      if (bus_req_o) begin
        if (ncyc < 4) begin
          log_a[ncyc] = bus_addr_o; log_w[ncyc] = bus_wr_o;
          log_b[ncyc] = bus_byte_o; log_d[ncyc] = bus_wdata_o;
        end
        ncyc++;
        @(negedge clk_i);
        bus_rdata_i = mem_word(bus_addr_o);
        bus_ack_i   = 1'b1;
        @(negedge clk_i);
        bus_ack_i   = 1'b0;
      end
    end
  end

  task automatic run(input bit wr, input logic [AW-1:0] a, input logic [1:0] len,
                     input logic [23:0] d, input bit poke);
    int t = 0;
    ncyc = 0;
    @(negedge clk_i);
    req_wr_i = wr; req_addr_i = a; req_len_i = len; req_wdata_i = d; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    if (poke) begin
      req_wr_i = ~wr; req_addr_i = a + 16'h40; req_len_i = 2'd3; req_wdata_i = 24'hFFFFFF;
      req_i = 1'b1;
      @(negedge clk_i);
      req_i = 1'b0;
    end
    while (!done_o && t < 100) begin @(negedge clk_i); t++; end
    chk(done_o, "R10 done seen", 32'(done_o), 32'd1);
  endtask

  task automatic cyc(input int i, input logic [AW-1:0] a, input bit w, input bit b,
                     input logic [15:0] d, input string tag);
    chk(log_a[i] == a, {tag, " addr"}, 32'(log_a[i]), 32'(a));
    chk(log_w[i] == w && log_b[i] == b, {tag, " kind"}, {log_w[i], log_b[i]}, {w, b});
    if (w) chk(log_d[i] == d, {tag, " data"}, 32'(log_d[i]), 32'(d));
  endtask

  task automatic t_reset;
    chk(!busy_o && !bus_req_o && !done_o, "R1 reset", {busy_o, bus_req_o, done_o}, 0);
  endtask

  task automatic t_rd_one;
    run(0, 16'h0100, 2'd1, 0, 0);
    chk(ncyc == 1, "R2 count even", ncyc, 1);
    cyc(0, 16'h0100, 0, 0, 0, "R2 c0");
    chk(rdata_o == {16'h0, mem_word(16'h0100)}, "R2 low", rdata_o, {16'h0, mem_word(16'h0100)});
    run(0, 16'h0103, 2'd1, 0, 0);
    chk(ncyc == 1, "R2 count odd", ncyc, 1);
    chk(rdata_o == {mem_word(16'h0102), 16'h0}, "R2 high", rdata_o, {mem_word(16'h0102), 16'h0});
    run(0, 16'h0102, 2'd2, 0, 0);
    chk(ncyc == 1, "R2 word count", ncyc, 1);
    chk(rdata_o == {mem_word(16'h0102), 16'h0}, "R2 word high", rdata_o, {mem_word(16'h0102), 16'h0});
    @(negedge clk_i);
    chk(!done_o, "R10 pulse", 32'(done_o), 0);
  endtask

  task automatic t_rd_two;
    run(0, 16'h0101, 2'd2, 0, 0);
    chk(ncyc == 2, "R3 count odd word", ncyc, 2);
    cyc(0, 16'h0101, 0, 0, 0, "R3 c0");
    cyc(1, 16'h0103, 0, 0, 0, "R3 c1");
    chk(rdata_o == {mem_word(16'h0102), mem_word(16'h0100)}, "R3 img",
        rdata_o, {mem_word(16'h0102), mem_word(16'h0100)});
    run(0, 16'h0104, 2'd3, 0, 0);
    chk(ncyc == 2, "R3 count tri", ncyc, 2);
    chk(rdata_o == {mem_word(16'h0106), mem_word(16'h0104)}, "R3 tri img",
        rdata_o, {mem_word(16'h0106), mem_word(16'h0104)});
  endtask

  task automatic t_wr_byte;
    run(1, 16'h0200, 2'd1, 24'h0000A7, 0);
    chk(ncyc == 1, "R5 count", ncyc, 1);
    cyc(0, 16'h0200, 1, 1, 16'h00A7, "R5 even");
    run(1, 16'h0201, 2'd1, 24'h00003C, 0);
    cyc(0, 16'h0201, 1, 1, 16'h3C00, "R5 odd");
  endtask

  task automatic t_wr_word;
    run(1, 16'h0202, 2'd2, 24'h00BEEF, 0);
    chk(ncyc == 1, "R6 even count", ncyc, 1);
    cyc(0, 16'h0202, 1, 0, 16'hBEEF, "R6 even");
    run(1, 16'h0203, 2'd2, 24'h001234, 0);
    chk(ncyc == 2, "R6 odd count", ncyc, 2);
    cyc(0, 16'h0203, 1, 1, 16'h3400, "R6 odd c0");
    cyc(1, 16'h0204, 1, 1, 16'h0012, "R6 odd c1");
  endtask

  task automatic t_wr_tri;
    run(1, 16'h0204, 2'd3, 24'hC0FFEE, 0);
    chk(ncyc == 2, "R7 count", ncyc, 2);
    cyc(0, 16'h0204, 1, 0, 16'hFFEE, "R7 c0");
    cyc(1, 16'h0206, 1, 1, 16'h00C0, "R7 c1");
    run(1, 16'h0205, 2'd3, 24'h123456, 0);
    chk(ncyc == 2, "R8 count", ncyc, 2);
    cyc(0, 16'h0205, 1, 1, 16'h5600, "R8 c0");
    cyc(1, 16'h0206, 1, 0, 16'h1234, "R8 c1");
  endtask

  task automatic t_ignore;
    run(1, 16'h0300, 2'd2, 24'h00ABCD, 1);
    chk(ncyc == 1, "R11 count", ncyc, 1);
    cyc(0, 16'h0300, 1, 0, 16'hABCD, "R11 c0");
    repeat (6) @(negedge clk_i);
    chk(!busy_o && ncyc == 1, "R11 no extra", ncyc, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_rd_one();
    t_rd_two();
    t_wr_byte();
    t_wr_word();
    t_wr_tri();
    t_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule